// File: doc/BRIEF.md
# Wide Two-Half Magnitude Comparator

This block decides one branch relation between two 128-bit operands. Each operand arrives as a low and a high 64-bit half. Every relation is built from half-width operations. Equality uses an XOR of each pair of halves, ORed together and reduced. Signed ordering takes the sign of a two-stage subtraction and corrects it with the overflow term. Unsigned ordering passes a borrow from the low halves into the high-half subtraction. A flag marks the second operand as the hardwired zero register. When the flag is set, the equality and signed paths take shortcuts that need no subtraction.

A 3-bit code selects the relation. Two codes are reserved and always give a false result. An optional output register, on by default, captures the result together with a valid strobe, so the comparator can sit between pipeline stages.

Top module: `wide_cmp`

## Requirements
- R1: Code 0 (equal) gives result 1 exactly when the 128-bit values {a_hi,a_lo} and {b_hi,b_lo} are identical.
- R2: Code 1 (not equal) gives the inverse of the code 0 result for the same operands.
- R3: Code 4 (signed less) gives 1 when operand a is below operand b, with both read as 128-bit two's complement numbers whose sign is bit 63 of the high half.
- R4: Code 5 (signed greater-or-equal) gives the inverse of the code 4 result.
- R5: Code 6 (unsigned less) gives 1 when a is below b, with both read as unsigned 128-bit numbers.
- R6: Code 7 (unsigned greater-or-equal) gives the inverse of the code 6 result.
- R7: Codes 2 and 3 give result 0 for any operands.
- R8: While b_zero_i is 1, the b halves have no effect, and every code behaves as if operand b were zero.
- R9: With the output register enabled, valid_o equals valid_i of the previous clock edge. result_o holds the relation of the operands sampled at that edge, and it is 0 after any edge where valid_i was 0.
- R10: While rst_ni is low, valid_o and result_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry a request this cycle |
| a_lo_i | input | 64 | Operand a, bits 63..0 |
| a_hi_i | input | 64 | Operand a, bits 127..64 |
| b_lo_i | input | 64 | Operand b, bits 63..0 |
| b_hi_i | input | 64 | Operand b, bits 127..64 |
| cond_i | input | 3 | Relation code (0 eq, 1 ne, 4 lt, 5 ge, 6 ltu, 7 geu, 2/3 reserved) |
| b_zero_i | input | 1 | Operand b is the zero register |
| valid_o | output | 1 | Result valid |
| result_o | output | 1 | Relation outcome |

## Verification
A set of corner values is applied to both operands under every code, in every pairing. The values are zero, all ones, the most negative and most positive numbers, and one. These pairs separate the signed decision from the unsigned one, because the same bit patterns order differently under the two readings. They also exercise the overflow correction, for example most-negative against most-positive. Operand pairs that agree in one half and differ only in the other show whether the low-half borrow and both XOR halves take part in the decision. Random operands with b_zero_i set and random b halves show that the zero shortcuts ignore b. Cycles without a request confirm that the output clears.

// File: rtl/wide_cmp_pkg.sv
package wide_cmp_pkg;
  typedef enum logic [2:0] {
    CC_EQ   = 3'd0,
    CC_NE   = 3'd1,
    CC_RS2  = 3'd2,
    CC_RS3  = 3'd3,
    CC_LT   = 3'd4,
    CC_GE   = 3'd5,
    CC_LTU  = 3'd6,
    CC_GEU  = 3'd7
  } cmp_cond_e;
endpackage

// File: rtl/cmp_eq_unit.sv
module cmp_eq_unit #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0] a_lo_i,
  input  logic [HALF_W-1:0] a_hi_i,
  input  logic [HALF_W-1:0] b_lo_i,
  input  logic [HALF_W-1:0] b_hi_i,
  input  logic              b_zero_i,
  output logic              eq_o
);
  logic [HALF_W-1:0] diff_bits;

  always_comb begin
    if (b_zero_i) diff_bits = a_lo_i | a_hi_i;
    else          diff_bits = (a_lo_i ^ b_lo_i) | (a_hi_i ^ b_hi_i);
  end

  assign eq_o = ~|diff_bits;
endmodule

// File: rtl/cmp_slt_unit.sv
module cmp_slt_unit #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0] a_lo_i,
  input  logic [HALF_W-1:0] a_hi_i,
  input  logic [HALF_W-1:0] b_lo_i,
  input  logic [HALF_W-1:0] b_hi_i,
  input  logic              b_zero_i,
  output logic              lt_o
);
  localparam int MSB = HALF_W - 1;

  logic              lo_borrow;
  logic [HALF_W-1:0] diff_hi;
  logic              ovf;
  logic              unused_diff;

  assign lo_borrow   = a_lo_i < b_lo_i;
  assign diff_hi     = a_hi_i - b_hi_i - {{(HALF_W-1){1'b0}}, lo_borrow};
  // overflow only when operand signs differ and the result sign left a's sign
  assign ovf         = (diff_hi[MSB] ^ a_hi_i[MSB]) & (a_hi_i[MSB] ^ b_hi_i[MSB]);
  assign unused_diff = ^diff_hi[MSB-1:0];

  assign lt_o = b_zero_i ? a_hi_i[MSB] : (diff_hi[MSB] ^ ovf);
endmodule

// File: rtl/cmp_geu_unit.sv
module cmp_geu_unit #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0] a_lo_i,
  input  logic [HALF_W-1:0] a_hi_i,
  input  logic [HALF_W-1:0] b_lo_i,
  input  logic [HALF_W-1:0] b_hi_i,
  input  logic              b_zero_i,
  output logic              geu_o
);
  logic [HALF_W-1:0] b_lo_m, b_hi_m;
  logic              lo_borrow;
  logic [HALF_W:0]   hi_ext;
  logic              unused_hi;

  assign b_lo_m    = b_zero_i ? '0 : b_lo_i;
  assign b_hi_m    = b_zero_i ? '0 : b_hi_i;
  assign lo_borrow = a_lo_i < b_lo_m;
  // extra top bit catches the borrow out of the high half
  assign hi_ext    = {1'b0, a_hi_i} - {1'b0, b_hi_m} - {{HALF_W{1'b0}}, lo_borrow};
  assign unused_hi = ^hi_ext[HALF_W-1:0];
  assign geu_o     = ~hi_ext[HALF_W];
endmodule

// File: rtl/wide_cmp.sv
module wide_cmp
  import wide_cmp_pkg::*;
#(
  parameter int HALF_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [HALF_W-1:0] a_lo_i,
  input  logic [HALF_W-1:0] a_hi_i,
  input  logic [HALF_W-1:0] b_lo_i,
  input  logic [HALF_W-1:0] b_hi_i,
  input  logic [2:0]        cond_i,
  input  logic              b_zero_i,
  output logic              valid_o,
  output logic              result_o
);
  localparam int MSB = HALF_W - 1;

  logic      eq_w, lt_w, geu_w, res_c;
  cmp_cond_e cc;

  assign cc = cmp_cond_e'(cond_i);

  cmp_eq_unit #(.HALF_W(HALF_W)) u_eq (
    .a_lo_i(a_lo_i), .a_hi_i(a_hi_i), .b_lo_i(b_lo_i), .b_hi_i(b_hi_i),
    .b_zero_i(b_zero_i), .eq_o(eq_w)
  );

  cmp_slt_unit #(.HALF_W(HALF_W)) u_slt (
    .a_lo_i(a_lo_i), .a_hi_i(a_hi_i), .b_lo_i(b_lo_i), .b_hi_i(b_hi_i),
    .b_zero_i(b_zero_i), .lt_o(lt_w)
  );

  cmp_geu_unit #(.HALF_W(HALF_W)) u_geu (
    .a_lo_i(a_lo_i), .a_hi_i(a_hi_i), .b_lo_i(b_lo_i), .b_hi_i(b_hi_i),
    .b_zero_i(b_zero_i), .geu_o(geu_w)
  );

  always_comb begin
    unique case (cc)
      CC_EQ:   res_c = eq_w;
      CC_NE:   res_c = ~eq_w;
      CC_LT:   res_c = lt_w;
      CC_GE:   res_c = ~lt_w;
      CC_LTU:  res_c = ~geu_w;
      CC_GEU:  res_c = geu_w;
      default: res_c = 1'b0;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic valid_q, result_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_q  <= 1'b0;
          result_q <= 1'b0;
        end else begin
          valid_q  <= valid_i;
          result_q <= valid_i & res_c;
        end
      end

      assign valid_o  = valid_q;
      assign result_o = result_q;

      a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> valid_o == $past(valid_i));
      a_r9_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !result_o);
      a_r7_reserved_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && cond_i[2:1] == 2'b01) |=> !result_o);
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign valid_o    = valid_i;
      assign result_o   = valid_i & res_c;
    end
  endgenerate

  // cross-checks between independently built relations
  a_r1_eq_not_less: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_w |-> (geu_w && !lt_w));
  a_r3_sign_decides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b_zero_i && a_hi_i[MSB] != b_hi_i[MSB]) |-> (lt_w == a_hi_i[MSB]));
  a_r5_same_sign_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b_zero_i && a_hi_i[MSB] == b_hi_i[MSB]) |-> (lt_w == !geu_w));
  a_r8_zero_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_zero_i |-> geu_w);
endmodule

// File: tb/tb_wide_cmp.sv
module tb_wide_cmp;
  localparam int HW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [HW-1:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
  logic [2:0]    cond = 3'd0;
  logic          bz = 1'b0;
  logic          valid_o, result_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wide_cmp #(.HALF_W(HW), .REG_OUT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .a_lo_i(a_lo), .a_hi_i(a_hi), .b_lo_i(b_lo), .b_hi_i(b_hi),
    .cond_i(cond), .b_zero_i(bz), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic ref_rel(logic [127:0] a, logic [127:0] b, logic [2:0] c);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] c, logic z);
    string s;
    case (c)
      3'd0: s = "R1"; 3'd1: s = "R2"; 3'd4: s = "R3";
      3'd5: s = "R4"; 3'd6: s = "R5"; 3'd7: s = "R6";
      default: s = "R7";
    endcase
    if (z) s = {s, "/R8"};
    return s;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,result} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one request: drive at negedge, registered result seen at the next negedge (R9)
  task automatic apply(logic [127:0] a, logic [127:0] b, logic [2:0] c, logic z);
    logic [127:0] b_eff;
    @(negedge clk);
    valid_i = 1'b1; a_lo = a[63:0]; a_hi = a[127:64];
    b_lo = b[63:0]; b_hi = b[127:64]; cond = c; bz = z;
    b_eff = z ? 128'd0 : b;
    @(negedge clk);
    check(req_of(c, z), {valid_o, result_o}, {1'b1, ref_rel(a, b_eff, c)});
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    valid_i = 1'b0; cond = 3'd1; a_lo = '1; b_lo = '0;
    @(negedge clk);
    check("R9 idle", {valid_o, result_o}, 2'b00);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] corners [6];
    corners[0] = 128'd0;
    corners[1] = '1;
    corners[2] = {1'b1, 127'd0};
    corners[3] = {1'b0, {127{1'b1}}};
    corners[4] = 128'd1;
    corners[5] = {64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF};

    repeat (3) @(negedge clk);
    check("R10 reset", {valid_o, result_o}, 2'b00);
    rst_n = 1'b1;
    idle_cycle();

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int c = 0; c < 8; c++)
          apply(corners[i], corners[j], 3'(c), 1'b0);

    // equal in one half only
    for (int k = 0; k < 40; k++) begin
      logic [127:0] x, y;
      x = rnd128(); y = x;
      if (k % 2 == 0) y[63:0] = x[63:0] ^ (64'd1 << (k % 64));
      else            y[127:64] = x[127:64] ^ (64'd1 << (k % 64));
      for (int c = 0; c < 8; c++) apply(x, y, 3'(c), 1'b0);
    end

    // zero register flag with junk b halves
    for (int k = 0; k < 30; k++)
      for (int c = 0; c < 8; c++)
        apply((k < 6) ? corners[k] : rnd128(), rnd128(), 3'(c), 1'b1);

    for (int k = 0; k < 1500; k++) begin
      apply(rnd128(), rnd128(), 3'($urandom_range(0, 7)), 1'b0);
      if (k % 100 == 0) idle_cycle();
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule